// File: doc/BRIEF.md
# Quarter-Rate Real-to-Complex Downconverter

This block turns a stream of real samples into complex baseband. Each accepted sample is multiplied by a tone at one quarter of the sample rate, so the mixer only ever selects the sample, zero, or its negation. Both rails then pass through an 11-tap half-band low-pass filter. The filter does not decimate, so there is one output for every input. A settings write port holds an enable bit and a direction bit. The direction bit picks which way the tone rotates.

When the converter is disabled, the incoming I/Q pair is passed straight through. This path has the same two-cycle latency as the converter path, so a mode change never reorders or drops samples. When the converter is enabled it works in real mode and ignores the Q input. A build parameter removes the mixer and filter completely, leaving only the delayed pass-through.

Top module: `qr_downconv`

## Requirements
- R1: After reset, `out_valid`, `out_i` and `out_q` are all zero. The converter starts disabled with direction 0.
- R2: While the converter is disabled, an accepted pair (`in_i`, `in_q`) appears unchanged on (`out_i`, `out_q`) two clock cycles later.
- R3: The converter is enabled by bit 4 of the word written to the control address `CTRL_ADDR` (default 0). The other bits of that word have no effect.
- R4: The direction is bit 0 of the word written to `DIR_ADDR` (default 1). With a 2-bit phase p and input x, the mixer produces (x,0) at p=0 and (−x,0) at p=2. At p=1 it produces (0,−x) for direction 0 and (0,+x) for direction 1. At p=3 it produces (0,+x) for direction 0 and (0,−x) for direction 1.
- R5: The phase advances by one only on a valid sample while the converter is enabled. A control write that turns the converter on from the off state sets the phase to 0 and clears the filter history. A write that leaves it on does neither.
- R6: While the converter is enabled, `in_q` has no effect on the outputs.
- R7: Each rail is filtered with taps h[0..10] = 268, 0, −1720, 0, 9644, 16384, 9644, 0, −1720, 0, 268, scaled by 1/32768. The newest mixer output is at h[0]. The output is floor((sum + 16384) / 32768), clamped to the signed 16-bit range.
- R8: Every valid input produces exactly one valid output, two clock cycles later, in both modes. The mode used is the one in force when the sample was accepted.
- R9: Writes to any address other than the control and direction addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_stb | input | 1 | Settings write strobe |
| set_addr | input | AW | Settings write address |
| set_data | input | 32 | Settings write data |
| in_valid | input | 1 | Input sample valid |
| in_i | input | DW | Input I (real sample in converter mode) |
| in_q | input | DW | Input Q (ignored in converter mode) |
| out_valid | output | 1 | Output sample valid |
| out_i | output | DW | Output I |
| out_q | output | DW | Output Q |

## Verification
The bench targets the phase counter. It pauses the valid flag at random, changes direction in the middle of a stream, and re-enables after a disable. A counter that ran on idle cycles, or was not reset on re-enable, would misplace the zero and sign pattern. A wrong rotation sign or filter history left behind would give the wrong imaginary rail. Full-scale inputs including −32768 test the widened negation, and an impulse shows each tap in turn. Stray Q values in converter mode and junk bits written to the control word and to an unused address would show up as bypass output in the wrong mode or as corrupted samples.

// File: rtl/qr_downconv.sv
module qr_downconv #(
  parameter int DW        = 16,
  parameter int AW        = 8,
  parameter int CTRL_ADDR = 0,
  parameter int DIR_ADDR  = 1,
  parameter bit USE_CONV  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 set_stb,
  input  logic [AW-1:0]        set_addr,
  input  logic [31:0]          set_data,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);
  localparam int MW     = DW + 1;
  localparam int AccW   = MW + 20;
  localparam int NT     = 11;
  localparam int EN_BIT = 4;

  logic                 en_r, dir_r;
  logic [1:0]           ph;
  logic signed [DW-1:0] y_i, y_q;

  logic                 v1, m1;
  logic signed [DW-1:0] b_i1, b_q1;

  generate
    if (USE_CONV) begin : g_conv
      localparam logic signed [AccW-1:0] C0   = 16384;
      localparam logic signed [AccW-1:0] C1   = 9644;
      localparam logic signed [AccW-1:0] C3   = -1720;
      localparam logic signed [AccW-1:0] C5   = 268;
      localparam logic signed [AccW-1:0] HALF = 16384;
      localparam logic signed [AccW-1:0] MAXV = (1 <<< (DW-1)) - 1;
      localparam logic signed [AccW-1:0] MINV = -(1 <<< (DW-1));

      logic signed [MW-1:0]   tap [2][NT];
      logic signed [MW-1:0]   mx [2];
      logic signed [MW-1:0]   xi, nx;
      logic signed [AccW-1:0] acc [2];
      logic signed [AccW-1:0] sh  [2];
      logic signed [DW-1:0]   y   [2];
      logic                   ctrl_wr, dir_wr, turn_on;
      logic                   unused_bits;

      assign unused_bits = ^{set_data[31:EN_BIT+1], set_data[EN_BIT-1:1]};
      assign ctrl_wr = set_stb && (set_addr == AW'(CTRL_ADDR));
      assign dir_wr  = set_stb && (set_addr == AW'(DIR_ADDR));
      assign turn_on = ctrl_wr && set_data[EN_BIT] && !en_r;

      assign xi = MW'(in_i);
      assign nx = -xi;

      always_comb begin
        mx[0] = '0;
        mx[1] = '0;
        unique case (ph)
          2'd0: mx[0] = xi;
          2'd1: mx[1] = dir_r ? xi : nx;
          2'd2: mx[0] = nx;
          default: mx[1] = dir_r ? nx : xi;
        endcase
      end

      always_comb begin
        for (int r = 0; r < 2; r++) begin
          acc[r] = C5 * (AccW'(tap[r][0]) + AccW'(tap[r][10]))
                 + C3 * (AccW'(tap[r][2]) + AccW'(tap[r][8]))
                 + C1 * (AccW'(tap[r][4]) + AccW'(tap[r][6]))
                 + C0 *  AccW'(tap[r][5]);
          sh[r] = (acc[r] + HALF) >>> 15;
          if (sh[r] > MAXV)      y[r] = MAXV[DW-1:0];
          else if (sh[r] < MINV) y[r] = MINV[DW-1:0];
          else                   y[r] = sh[r][DW-1:0];
        end
      end

      assign y_i = y[0];
      assign y_q = y[1];

      always_ff @(posedge clk) begin
        if (rst) begin
          en_r  <= 1'b0;
          dir_r <= 1'b0;
          ph    <= 2'd0;
          for (int r = 0; r < 2; r++)
            for (int k = 0; k < NT; k++) tap[r][k] <= '0;
        end else begin
          if (ctrl_wr) en_r  <= set_data[EN_BIT];
          if (dir_wr)  dir_r <= set_data[0];
          if (turn_on) begin
            ph <= 2'd0;
            for (int r = 0; r < 2; r++)
              for (int k = 0; k < NT; k++) tap[r][k] <= '0;
          end else if (in_valid && en_r) begin
            ph <= 2'(ph + 2'd1);
            for (int r = 0; r < 2; r++) begin
              tap[r][0] <= mx[r];
              for (int k = 1; k < NT; k++) tap[r][k] <= tap[r][k-1];
            end
          end
        end
      end
    end else begin : g_pass
      logic unused_set;
      assign unused_set = ^{set_stb, set_addr, set_data};
      assign en_r  = 1'b0;
      assign dir_r = 1'b0;
      assign ph    = 2'd0;
      assign y_i   = '0;
      assign y_q   = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      v1        <= 1'b0;
      m1        <= 1'b0;
      b_i1      <= '0;
      b_q1      <= '0;
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      v1        <= in_valid;
      m1        <= en_r;
      out_valid <= v1;
      if (in_valid) begin
        b_i1 <= in_i;
        b_q1 <= in_q;
      end
      if (v1) begin
        out_i <= m1 ? y_i : b_i1;
        out_q <= m1 ? y_q : b_q1;
      end
    end
  end
endmodule

// File: rtl/qr_downconv_chk.sv
module qr_downconv_chk #(
  parameter int DW        = 16,
  parameter int AW        = 8,
  parameter int CTRL_ADDR = 0
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 set_stb,
  input logic [AW-1:0]        set_addr,
  input logic [31:0]          set_data,
  input logic                 in_valid,
  input logic signed [DW-1:0] in_i,
  input logic signed [DW-1:0] in_q,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_i,
  input logic signed [DW-1:0] out_q,
  input logic                 en_r,
  input logic [1:0]           ph
);
  a_r1_reset_outputs: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_i == '0 && out_q == '0));

  a_r8_valid_forward: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  a_r8_valid_backward: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));

  a_r2_bypass_pair: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !en_r) |-> ##2 (out_i == $past(in_i, 2) && out_q == $past(in_q, 2)));

  a_r5_phase_step: assert property (@(posedge clk) disable iff (rst)
    (in_valid && en_r && !set_stb) |=> ph == 2'($past(ph) + 2'd1));

  a_r5_phase_idle: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !set_stb) |=> $stable(ph));

  a_r5_enable_zero: assert property (@(posedge clk) disable iff (rst)
    (set_stb && set_addr == AW'(CTRL_ADDR) && set_data[4] && !en_r) |=> ph == 2'd0);
endmodule

bind qr_downconv qr_downconv_chk #(.DW(DW), .AW(AW), .CTRL_ADDR(CTRL_ADDR)) u_chk (.*);

// File: tb/tb_qr_downconv.sv
module tb_qr_downconv;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int QN = 8192;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 set_stb = 1'b0;
  logic [AW-1:0]        set_addr = '0;
  logic [31:0]          set_data = '0;
  logic                 in_valid = 1'b0;
  logic signed [DW-1:0] in_i = '0, in_q = '0;
  logic                 out_valid;
  logic signed [DW-1:0] out_i, out_q;

  always #4 clk = ~clk;

  qr_downconv #(.DW(DW), .AW(AW)) dut (
    .clk(clk), .rst(rst), .set_stb(set_stb), .set_addr(set_addr), .set_data(set_data),
    .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q));

  int checks = 0, fails = 0, cyc = 0, wp = 0, rp = 0;
  bit done = 0;
  longint eq_i [QN];
  longint eq_q [QN];
  int     eq_c [QN];
  string  eq_t [QN];
  string  cur_tag = "R2";
  longint mi [11];
  longint mq [11];
  longint hc [11] = '{268, 0, -1720, 0, 9644, 16384, 9644, 0, -1720, 0, 268};
  bit m_en = 0, m_dir = 0;
  int m_ph = 0;
  logic [31:0] lfsr = 32'h1ACE_5EED;

  function automatic longint filt(input bit rail);
    longint acc = 0, y;
    for (int k = 0; k < 11; k++) acc += hc[k] * (rail ? mq[k] : mi[k]);
    y = (acc + 16384) >>> 15;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    return y;
  endfunction

  function automatic void push(input longint a, input longint b);
    eq_i[wp % QN] = a;
    eq_q[wp % QN] = b;
    eq_c[wp % QN] = cyc + 2;
    eq_t[wp % QN] = cur_tag;
    wp++;
  endfunction

  function automatic void model_sample(input longint x, input longint qv);
    longint a = 0, b = 0;
    if (!m_en) begin
      push(x, qv);
      return;
    end
    case (m_ph)
      0: a = x;
      1: b = m_dir ? x : -x;
      2: a = -x;
      default: b = m_dir ? -x : x;
    endcase
    for (int k = 10; k > 0; k--) begin
      mi[k] = mi[k-1];
      mq[k] = mq[k-1];
    end
    mi[0] = a;
    mq[0] = b;
    push(filt(0), filt(1));
    m_ph = (m_ph + 1) % 4;
  endfunction

  function automatic logic [31:0] rnd();
    lfsr ^= lfsr << 13;
    lfsr ^= lfsr >> 17;
    lfsr ^= lfsr << 5;
    return lfsr;
  endfunction

  task automatic check_out();
    if (!out_valid) return;
    checks++;
    if (rp == wp) begin
      fails++;
      $display("FAIL R8 unexpected output actual=(%0d,%0d) expected=none", out_i, out_q);
      return;
    end
    if (eq_c[rp % QN] != cyc) begin
      fails++;
      $display("FAIL R8 latency actual_cycle=%0d expected_cycle=%0d", cyc, eq_c[rp % QN]);
    end else if (longint'(out_i) != eq_i[rp % QN] || longint'(out_q) != eq_q[rp % QN]) begin
      fails++;
      $display("FAIL %s actual=(%0d,%0d) expected=(%0d,%0d)", eq_t[rp % QN],
               out_i, out_q, eq_i[rp % QN], eq_q[rp % QN]);
    end
    rp++;
  endtask

  task automatic step(input bit v, input logic signed [DW-1:0] a, input logic signed [DW-1:0] b);
    @(negedge clk);
    cyc++;
    check_out();
    set_stb  = 1'b0;
    in_valid = v;
    in_i     = a;
    in_q     = b;
    if (v) model_sample(longint'(a), longint'(b));
  endtask

  task automatic wr(input logic [AW-1:0] addr, input logic [31:0] data);
    @(negedge clk);
    cyc++;
    check_out();
    in_valid = 1'b0;
    set_stb  = 1'b1;
    set_addr = addr;
    set_data = data;
    if (addr == 0) begin
      if (data[4] && !m_en) begin
        m_ph = 0;
        for (int k = 0; k < 11; k++) begin mi[k] = 0; mq[k] = 0; end
      end
      m_en = data[4];
    end else if (addr == 1) m_dir = data[0];
  endtask

  function automatic logic signed [DW-1:0] sval(input logic [31:0] r);
    if (r[22:20] == 3'd0) return 16'sh8000;
    if (r[22:20] == 3'd1) return 16'sh7FFF;
    return r[15:0];
  endfunction

  task automatic burst(input int n, input int vpct);
    for (int k = 0; k < n; k++) begin
      logic [31:0] r = rnd();
      logic [31:0] r2 = rnd();
      step((r[31:24] % 100) < vpct, sval(r), r2[15:0]);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    for (int k = 0; k < 11; k++) begin mi[k] = 0; mq[k] = 0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      cyc++;
      checks++;
      if (out_valid !== 1'b0 || out_i !== '0 || out_q !== '0) begin
        fails++;
        $display("FAIL R1 actual=(%0b,%0d,%0d) expected=(0,0,0)", out_valid, out_i, out_q);
      end
    end

    cur_tag = "R1 R2 bypass";
    step(1, 16'sh8000, 16'sh7FFF);
    step(1, 16'sh7FFF, 16'sh8000);
    step(1, 0, -1);
    burst(300, 70);

    cur_tag = "R3 other control bits";
    wr(0, 32'hFFFF_FFEF);
    burst(60, 80);
    cur_tag = "R9 stray address";
    wr(5, 32'hFFFF_FFFF);
    burst(60, 80);

    cur_tag = "R7 impulse";
    wr(0, 32'h0000_0010);
    step(1, 1000, 0);
    for (int k = 0; k < 14; k++) step(1, 0, 0);
    step(1, 0, 0);
    step(1, -20000, 0);
    for (int k = 0; k < 14; k++) step(1, 0, 0);

    cur_tag = "R4 R6 dir0";
    burst(600, 75);
    cur_tag = "R7 full scale";
    for (int k = 0; k < 40; k++) step(1, (k % 3 == 0) ? 16'sh8000 : 16'sh7FFF, 16'sh1234);
    cur_tag = "R4 R6 dir1";
    wr(1, 32'h0000_0001);
    burst(600, 75);
    cur_tag = "R9 stray address dir";
    wr(7, 32'h0000_0000);
    burst(100, 60);

    cur_tag = "R5 gaps";
    burst(400, 30);
    cur_tag = "R5 enable again no clear";
    wr(0, 32'h0000_0010);
    burst(100, 60);
    cur_tag = "R8 mode switch";
    step(1, 1234, 4321);
    wr(0, 32'h0000_0000);
    step(1, 555, -555);
    step(1, -777, 777);
    burst(40, 70);
    cur_tag = "R5 reenable clears";
    wr(0, 32'h0000_0010);
    burst(200, 70);
    wr(1, 32'h0000_0000);
    cur_tag = "R4 dir back";
    burst(200, 90);

    for (int k = 0; k < 6; k++) step(0, 0, 0);
    checks++;
    if (rp != wp) begin
      fails++;
      $display("FAIL R8 outputs actual=%0d expected=%0d", rp, wp);
    end
    done = 1;
    summary();
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end
endmodule